// File: doc/BRIEF.md
# MESI Coherence Invariant Monitor

This block watches the coherence state that every core holds for a single cache line and decides, every cycle, whether that set of states can occur under the four-state MESI protocol. Each core reports its copy as a 2-bit code on a packed input vector. The block counts how many copies sit in each of the four states and drives those counts out directly. From the counts alone it derives a combinational legality signal.

A check strobe qualifies the legality signal. On any clock edge where the strobe is high and the combination is illegal, a sticky error flag is set. The flag stays set until synchronous reset. The monitor only observes. It never reads line data and never takes part in the protocol. It is meant to sit beside a coherence controller whose core count matches its parameter, so that a protocol bug is caught at the edge where it first appears.

Top module: `mesi_inv_monitor`

## Requirements
- R1: Core k reports its state on `core_state[2k+1:2k]`, using the codes Modified = 0, Exclusive = 1, Shared = 2 and Invalid = 3.
- R2: `cnt_mod`, `cnt_exc`, `cnt_shr` and `cnt_inv` give, in the same cycle, the number of cores holding each code, and the four always sum to N.
- R3: A single Modified copy with every other core Invalid is legal (`legal` = 1).
- R4: A single Exclusive copy with every other core Invalid is legal.
- R5: Two or more Shared copies with every other core Invalid are legal.
- R6: All cores Invalid is legal, and so is exactly one Shared copy with the rest Invalid.
- R7: Any Modified or Exclusive copy together with at least one other non-Invalid copy is illegal (`legal` = 0). This covers two M, two E, M with E, M with S and E with S.
- R8: When `chk_en` is 1 and `legal` is 0 at a rising clock edge, `err` reads 1 after that edge. A strobed legal combination never sets it.
- R9: Once `err` is set it stays 1 until reset. An illegal combination while `chk_en` is 0 leaves `err` unchanged.
- R10: A rising edge with `rst` = 1 clears `err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Check strobe that qualifies the legality result |
| core_state | input | 2*N | Packed per-core state codes, 2 bits per core |
| cnt_mod | output | clog2(N+1) | Number of cores in Modified |
| cnt_exc | output | clog2(N+1) | Number of cores in Exclusive |
| cnt_shr | output | clog2(N+1) | Number of cores in Shared |
| cnt_inv | output | clog2(N+1) | Number of cores in Invalid |
| legal | output | 1 | Combination is allowed under MESI (combinational) |
| err | output | 1 | Sticky error, set by a strobed illegal combination |

## Verification
A miscount in the tally appears at the four count outputs in the same cycle that the state vector changes. It also breaks their fixed sum of N. A wrong legality rule shows up at once on `legal`. One clock edge later it shows up on `err`, and only when the strobe is high. A faulty flag register shows as an `err` that fails to rise the edge after a strobed illegal cycle, drops without reset, or rises while the strobe is low. Each of these can be seen within one cycle of the stimulus that exposes it.

// File: rtl/mesi_inv_pkg.sv
package mesi_inv_pkg;

  // Per-core coherence code carried on the packed state vector
  typedef enum logic [1:0] {
    ST_MOD = 2'd0,
    ST_EXC = 2'd1,
    ST_SHR = 2'd2,
    ST_INV = 2'd3
  } line_st_e;

  localparam int ST_BITS = 2;

endpackage

// File: rtl/mesi_state_tally.sv
module mesi_state_tally
  import mesi_inv_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [ST_BITS*N-1:0] st_vec,
  output logic [CW-1:0]        n_mod,
  output logic [CW-1:0]        n_exc,
  output logic [CW-1:0]        n_shr,
  output logic [CW-1:0]        n_inv
);

  logic [N-1:0] hit_m;
  logic [N-1:0] hit_e;
  logic [N-1:0] hit_s;
  logic [N-1:0] hit_i;

  // one-hot decode per core
  for (genvar k = 0; k < N; k++) begin : g_dec
    logic [ST_BITS-1:0] code;
    assign code     = st_vec[ST_BITS*k +: ST_BITS];
    assign hit_m[k] = (code == ST_MOD);
    assign hit_e[k] = (code == ST_EXC);
    assign hit_s[k] = (code == ST_SHR);
    assign hit_i[k] = (code == ST_INV);
  end

  // population counts
  always_comb begin
    n_mod = '0;
    n_exc = '0;
    n_shr = '0;
    n_inv = '0;
    for (int k = 0; k < N; k++) begin
      n_mod = n_mod + CW'(hit_m[k]);
      n_exc = n_exc + CW'(hit_e[k]);
      n_shr = n_shr + CW'(hit_s[k]);
      n_inv = n_inv + CW'(hit_i[k]);
    end
  end

endmodule

// File: rtl/mesi_legal_rule.sv
module mesi_legal_rule #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [CW-1:0] n_mod,
  input  logic [CW-1:0] n_exc,
  input  logic [CW-1:0] n_inv,
  output logic          ok
);

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] REST = CW'(N - 1);

  logic sole_owner_m;
  logic sole_owner_e;
  logic clean_shared;

  // Owner states must be alone among the valid copies; without owners
  // any mix of Shared and Invalid (including none Shared) is allowed.
  assign sole_owner_m = (n_mod == ONE) && (n_inv == REST);
  assign sole_owner_e = (n_exc == ONE) && (n_inv == REST);
  assign clean_shared = (n_mod == '0) && (n_exc == '0);
  assign ok           = sole_owner_m || sole_owner_e || clean_shared;

endmodule

// File: rtl/mesi_sticky_flag.sv
module mesi_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end
  end

endmodule

// File: rtl/mesi_inv_monitor.sv
module mesi_inv_monitor
  import mesi_inv_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chk_en,
  input  logic [ST_BITS*N-1:0] core_state,
  output logic [CW-1:0]        cnt_mod,
  output logic [CW-1:0]        cnt_exc,
  output logic [CW-1:0]        cnt_shr,
  output logic [CW-1:0]        cnt_inv,
  output logic                 legal,
  output logic                 err
);

  logic violation;

  mesi_state_tally #(.N(N), .CW(CW)) u_tally (
    .st_vec (core_state),
    .n_mod  (cnt_mod),
    .n_exc  (cnt_exc),
    .n_shr  (cnt_shr),
    .n_inv  (cnt_inv)
  );

  mesi_legal_rule #(.N(N), .CW(CW)) u_rule (
    .n_mod (cnt_mod),
    .n_exc (cnt_exc),
    .n_inv (cnt_inv),
    .ok    (legal)
  );

  assign violation = chk_en && !legal;

  mesi_sticky_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (violation),
    .flag_o (err)
  );

endmodule

// File: rtl/mesi_inv_monitor_chk.sv
module mesi_inv_monitor_chk #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          chk_en,
  input logic [CW-1:0] cnt_mod,
  input logic [CW-1:0] cnt_exc,
  input logic [CW-1:0] cnt_shr,
  input logic [CW-1:0] cnt_inv,
  input logic          legal,
  input logic          err
);

  // R2: the four tallies partition the cores
  a_r2_sum_is_n: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_mod) + int'(cnt_exc) + int'(cnt_shr) + int'(cnt_inv)) == N);

  // R5 / R6: no owner present means the combination is accepted
  a_r5_no_owner_ok: assert property (@(posedge clk) disable iff (rst)
    (cnt_mod == '0 && cnt_exc == '0) |-> legal);

  // R7: an owner with company is rejected
  a_r7_owner_alone: assert property (@(posedge clk) disable iff (rst)
    ((cnt_mod != '0 || cnt_exc != '0) && int'(cnt_inv) != N - 1) |-> !legal);

  // R8: strobed violation sets the flag after the edge
  a_r8_err_sets: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !legal) |=> err);

  // R9: the flag holds until reset
  a_r9_err_holds: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R9: no rise without a strobed violation
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!err && !(chk_en && !legal)) |=> !err);

  // R10: reset clears the flag
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !err);

endmodule

bind mesi_inv_monitor mesi_inv_monitor_chk #(.N(N), .CW(CW)) u_inv_chk (
  .clk     (clk),
  .rst     (rst),
  .chk_en  (chk_en),
  .cnt_mod (cnt_mod),
  .cnt_exc (cnt_exc),
  .cnt_shr (cnt_shr),
  .cnt_inv (cnt_inv),
  .legal   (legal),
  .err     (err)
);

// File: tb/test_mesi_inv_monitor.sv
`timescale 1ns/1ps
module test_mesi_inv_monitor;

  localparam int NC = 8;
  localparam int CWB = $clog2(NC + 1);
  localparam logic [1:0] CM = 2'd0, CE = 2'd1, CS = 2'd2, CI = 2'd3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              chk_en = 1'b0;
  logic [2*NC-1:0]   core_state = '1;
  logic [CWB-1:0]    cnt_mod, cnt_exc, cnt_shr, cnt_inv;
  logic              legal, err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic err_exp = 1'b0;

  always #4 clk = ~clk;

  mesi_inv_monitor #(.N(NC)) i_mesi_inv_monitor (
    .clk(clk), .rst(rst), .chk_en(chk_en), .core_state(core_state),
    .cnt_mod(cnt_mod), .cnt_exc(cnt_exc), .cnt_shr(cnt_shr),
    .cnt_inv(cnt_inv), .legal(legal), .err(err)
  );

  // ---------------- reference model ----------------
  function automatic int ref_count(logic [2*NC-1:0] v, logic [1:0] code);
    int c = 0;
    for (int k = 0; k < NC; k++) if (v[2*k +: 2] == code) c++;
    return c;
  endfunction

  // pairwise form: owners share with nobody valid, S pairs with S or I
  function automatic logic ref_legal(logic [2*NC-1:0] v);
    for (int a = 0; a < NC; a++)
      for (int b = a + 1; b < NC; b++) begin
        logic [1:0] x = v[2*a +: 2];
        logic [1:0] y = v[2*b +: 2];
        if (x != CI && y != CI && (x != CS || y != CS)) return 1'b0;
      end
    return 1'b1;
  endfunction

  function automatic logic [2*NC-1:0] put(logic [2*NC-1:0] v, int k, logic [1:0] c);
    logic [2*NC-1:0] r = v;
    r[2*k +: 2] = c;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (state %h)", req, act, exp, core_state);
    end
  endtask

  // R1/R2 counts and the legality result for the current vector
  task automatic chk_comb(string req);
    chk("R2 cnt_mod", int'(cnt_mod), ref_count(core_state, CM));
    chk("R2 cnt_exc", int'(cnt_exc), ref_count(core_state, CE));
    chk("R2 cnt_shr", int'(cnt_shr), ref_count(core_state, CS));
    chk("R2 cnt_inv", int'(cnt_inv), ref_count(core_state, CI));
    chk(req, int'(legal), int'(ref_legal(core_state)));
  endtask

  // one cycle: check err from earlier edges, apply, check comb, predict edge
  task automatic step(logic [2*NC-1:0] v, logic en, logic r, string req);
    @(negedge clk);
    chk("R9 err tracking", int'(err), int'(err_exp));
    core_state = v;
    chk_en     = en;
    rst        = r;
    #1;
    chk_comb(req);
    if (r) err_exp = 1'b0;
    else   err_exp = err_exp | (en & ~ref_legal(v));
  endtask

  function automatic logic [2*NC-1:0] rand_vec();
    logic [2*NC-1:0] v = '1;
    int mode = int'($urandom % 4);
    case (mode)
      0: v = put(v, int'($urandom % NC), ($urandom % 2) == 0 ? CM : CE);
      1: for (int k = 0; k < NC; k++) if ($urandom % 2 == 0) v = put(v, k, CS);
      2: for (int k = 0; k < NC; k++) v = put(v, k, 2'($urandom % 4));
      default: begin
        v = put(v, int'($urandom % NC), 2'($urandom % 3));
        v = put(v, int'($urandom % NC), 2'($urandom % 3));
      end
    endcase
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2*NC-1:0] allI = '1;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 err after reset", int'(err), 0);
    err_exp = 1'b0;

    // directed corner cases, strobe low (R9: must not set err)
    step(allI,                                   1'b0, 1'b0, "R6 all invalid");
    step(put(allI, 3, CS),                       1'b0, 1'b0, "R6 single shared");
    step(put(allI, 0, CM),                       1'b0, 1'b0, "R3 sole modified");
    step(put(allI, NC-1, CE),                    1'b0, 1'b0, "R4 sole exclusive");
    step(put(put(put(allI,1,CS),4,CS),6,CS),     1'b0, 1'b0, "R5 three shared");
    step({NC{CS}},                               1'b0, 1'b0, "R5 all shared");
    step(put(put(allI,2,CM),5,CS),               1'b0, 1'b0, "R7 M with S");
    step(put(put(allI,0,CE),7,CE),               1'b0, 1'b0, "R7 two E");
    step(put(put(allI,3,CM),4,CE),               1'b0, 1'b0, "R7 M with E");
    step(put(put(allI,1,CE),2,CS),               1'b0, 1'b0, "R7 E with S");
    step({NC{CM}},                               1'b0, 1'b0, "R7 all M");
    step(allI,                                   1'b0, 1'b0, "R9 strobe low");
    @(negedge clk);
    chk("R9 illegal unstrobed leaves err", int'(err), 0);

    // strobed legal must not set, strobed illegal must set and hold
    step({NC{CS}},                               1'b1, 1'b0, "R8 strobed legal");
    step(put(put(allI,0,CM),1,CM),               1'b1, 1'b0, "R8 strobed illegal");
    step(allI,                                   1'b0, 1'b0, "R6 all invalid");
    @(negedge clk);
    chk("R8 err set", int'(err), 1);
    repeat (4) step(allI, 1'b1, 1'b0, "R9 held");
    step(allI,                                   1'b0, 1'b1, "R10 reset");
    step(allI,                                   1'b0, 1'b0, "R6 all invalid");
    chk("R10 err cleared", int'(err), 0);

    // constrained random, strobe and rare reset randomised
    for (int i = 0; i < 600; i++) begin
      logic en = ($urandom % 8) == 0;
      logic r  = ($urandom % 64) == 0;
      step(rand_vec(), en, r, "R7 random legality");
    end
    @(negedge clk);
    chk("R9 err final", int'(err), int'(err_exp));
    finish_run();
  end

endmodule